// File: doc/BRIEF.md
# Time-Shared Ping-Pong Sub-Window Address Buffer

This block carries the addresses of surviving sub-windows from one detection stage to the next while the stages work on different frames at once. It offers two links: link 0 feeds the second stage from the first, and link 1 feeds the final stage from the first two. Each link is a ping-pong pair of logical address queues. During a frame the producing stage appends 32-bit entries (linear position plus scale) to one side of the pair. Meanwhile the consuming stage reads back, in order, what was written to the other side during the previous frame. A single `frame_swap` pulse exchanges the two roles of both links at once.

All four logical queues live in one external single-port memory, each in its own address region. The swap is therefore a change of region selection and not a rewiring of memories. Each queue has a small front FIFO. A write-role queue uses it to hold pushed entries until its turn on the memory port. A read-role queue uses it to prefetch entries ahead of the consumer. A round-robin arbiter hands the memory port to one queue per cycle. An illegal pop or push is ignored and reported with a one-cycle error flag.

Top module: `pingpong_addr_buf`

## Requirements
- R1: Every entry accepted on a link during a frame is presented on that link's `pop_data` during the next frame, in acceptance order. `pop_valid` marks a presented entry. A pop in a cycle with `pop_valid` high consumes the entry, and `pop_valid` falls only after a pop or a swap.
- R2: A `frame_swap` pulse exchanges the write and read sides of both links. Entries of the read side that were never popped are discarded and do not appear in any later frame.
- R3: In the cycle after `frame_swap`, `pop_valid` is low on both links. After reset it is low as well.
- R4: A pop while `pop_valid` is low raises `pop_err` for that link in the next cycle and changes no stored entry. A legal pop never raises `pop_err`.
- R5: A push while the write side's front FIFO already holds `FIFO_DEPTH` unwritten entries is dropped and raises `push_err` in the next cycle. The entries accepted before and after it keep their order. An accepted push never raises `push_err`.
- R6: A queue holds at most 2^`BANK_AW` entries per frame. A push beyond that count is dropped with `push_err` in the next cycle.
- R7: The memory address is {link (1 bit), side (1 bit), offset (`BANK_AW` bits)}, with link in the top bit. Side 0 is the write side of both links after reset. Within a frame, the writes of a queue use offsets 0, 1, 2, … in order, and the reads of a queue after its swap to the read side also start at offset 0 and run in order.
- R8: The memory port makes at most one access per cycle, granted round-robin among the four queues. It stays idle (`mem_en` low) when no queue has entries to write or to fetch. Read data is taken from `mem_rdata` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_swap | input | 1 | One-cycle pulse at a frame boundary; swaps the sides of both links |
| push_valid | input | 2 | Per-link push strobe |
| push_data | input | 2*DATA_W | Per-link entry, link l at bits [l*DATA_W +: DATA_W] |
| push_err | output | 2 | Per-link push rejected, one cycle after the push |
| pop_req | input | 2 | Per-link pop strobe |
| pop_valid | output | 2 | Per-link entry available at pop_data |
| pop_data | output | 2*DATA_W | Per-link head entry of the read side |
| pop_err | output | 2 | Per-link pop while empty, one cycle after the pop |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | BANK_AW+2 | {link, side, offset} |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The hardest condition to reach from the ports is a full front FIFO on a write side, because the drain rate depends on arbitration that the ports do not show. The bench builds it with a frame in which both read sides have nothing to fetch, so exactly two queues compete. Both links then push every cycle for twelve cycles, which outruns a drain rate of at most one in two against a depth-4 FIFO, and no per-frame capacity limit comes into play. The bench records which pushes were accepted from `push_err`, then demands that the next frame reads back exactly those entries in order. The capacity limit is reached separately by pushing one entry more than a 16-entry queue holds at a slow rate.

// File: rtl/ppab_pkg.sv
package ppab_pkg;

    localparam int NUM_LINKS  = 2;
    localparam int SIDES      = 2;
    localparam int NUM_BANKS  = NUM_LINKS * SIDES;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);

    typedef enum logic {
        ROLE_WRITE = 1'b0,
        ROLE_READ  = 1'b1
    } role_e;

    // Logical queue index: link in the upper bit, side in the lower bit.
    function automatic int bank_of(int link, logic side);
        return link * SIDES + int'(side);
    endfunction

endpackage

// File: rtl/ppab_fifo.sv
module ppab_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 10,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;

    function automatic logic [PW-1:0] step_ptr(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            level <= level + LVL_W'(push) - LVL_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) slots[wp] <= din;
    end

    assign head  = slots[rp];
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

endmodule

// File: rtl/ppab_rr_arb.sv
module ppab_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);

    logic [IW-1:0] prio;

    always_comb begin
        int cand;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(prio) + k) % N;
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(cand);
            end
        end
        gnt = gnt_any ? (N'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= '0;
        end else if (gnt_any) begin
            prio <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
        end
    end

endmodule

// File: rtl/ppab_bank.sv
module ppab_bank import ppab_pkg::*; #(
    parameter int W     = 32,
    parameter int DEPTH = 10,
    parameter int AW    = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  role_e         role,
    input  logic          swap,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          gnt,
    input  logic          ret_valid,
    input  logic [W-1:0]  ret_data,
    output logic          req,
    output logic          req_we,
    output logic [AW-1:0] req_off,
    output logic [W-1:0]  req_wdata,
    output logic [W-1:0]  head,
    output logic          avail,
    output logic          can_push
);

    localparam logic [CNT_W-1:0] CAP = {1'b1, {AW{1'b0}}};

    logic [LVL_W-1:0] level, level_n, drain_left;
    logic             empty, full;
    logic [CNT_W-1:0] wcnt, wcnt_n, to_fetch, stored;
    logic [AW-1:0]    rd_ptr;
    logic             is_wr, draining, fetch_ok;
    logic             acc_push, wr_done, rd_issue;
    logic             fifo_push, fifo_pop, flush;
    logic [W-1:0]     fifo_din;

    assign is_wr    = (role == ROLE_WRITE);
    assign stored   = wcnt + CNT_W'(level);
    assign can_push = is_wr && !full && (stored < CAP);
    assign acc_push = push && can_push;
    assign draining = !is_wr && (drain_left != '0);
    assign fetch_ok = !is_wr && !draining && (to_fetch != '0) &&
                      ((LVL_W+1)'(level) + (LVL_W+1)'(ret_valid) < (LVL_W+1)'(DEPTH));

    always_comb begin
        req     = 1'b0;
        req_we  = 1'b0;
        req_off = wcnt[AW-1:0];
        if (is_wr || draining) begin
            req    = !empty;
            req_we = 1'b1;
        end else if (fetch_ok) begin
            req     = 1'b1;
            req_off = rd_ptr;
        end
    end

    assign req_wdata = head;
    assign wr_done   = gnt && req_we;
    assign rd_issue  = gnt && !req_we;
    assign avail     = !is_wr && !draining && !empty;
    assign fifo_push = acc_push || (!is_wr && ret_valid);
    assign fifo_din  = is_wr ? push_data : ret_data;
    assign fifo_pop  = wr_done || (pop && avail);
    assign flush     = swap && !is_wr;
    assign level_n   = level + LVL_W'(fifo_push) - LVL_W'(fifo_pop);
    assign wcnt_n    = wcnt + CNT_W'(wr_done);

    ppab_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .head  (head),
        .level (level),
        .empty (empty),
        .full  (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt       <= '0;
            to_fetch   <= '0;
            drain_left <= '0;
            rd_ptr     <= '0;
        end else if (swap) begin
            rd_ptr <= '0;
            if (is_wr) begin
                // Frame closes: everything written so far, including what
                // still waits in the front FIFO, becomes the read quota.
                wcnt       <= wcnt_n;
                to_fetch   <= wcnt_n + CNT_W'(level_n);
                drain_left <= level_n;
            end else begin
                wcnt       <= '0;
                to_fetch   <= '0;
                drain_left <= '0;
            end
        end else begin
            wcnt <= wcnt_n;
            if (wr_done && draining) drain_left <= drain_left - LVL_W'(1);
            if (rd_issue) begin
                rd_ptr   <= rd_ptr + AW'(1);
                to_fetch <= to_fetch - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pingpong_addr_buf.sv
module pingpong_addr_buf import ppab_pkg::*; #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 10,
    parameter int BANK_AW    = 16,
    localparam int ADDR_W = BANK_IDX_W + BANK_AW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_swap,
    input  logic [NUM_LINKS-1:0]          push_valid,
    input  logic [NUM_LINKS*DATA_W-1:0]   push_data,
    output logic [NUM_LINKS-1:0]          push_err,
    input  logic [NUM_LINKS-1:0]          pop_req,
    output logic [NUM_LINKS-1:0]          pop_valid,
    output logic [NUM_LINKS*DATA_W-1:0]   pop_data,
    output logic [NUM_LINKS-1:0]          pop_err,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata
);

    logic [NUM_LINKS-1:0]  wr_side;
    logic [NUM_BANKS-1:0]  b_req, b_we, b_avail, b_can_push, b_ret;
    logic [BANK_AW-1:0]    b_off   [NUM_BANKS];
    logic [DATA_W-1:0]     b_wdata [NUM_BANKS];
    logic [DATA_W-1:0]     b_head  [NUM_BANKS];
    logic [NUM_BANKS-1:0]  arb_gnt;
    logic [BANK_IDX_W-1:0] arb_idx;
    logic                  arb_any;
    logic                  ret_v_q;
    logic [BANK_IDX_W-1:0] ret_bank_q;
    logic [NUM_LINKS-1:0]  link_can_push;

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        for (genvar s = 0; s < SIDES; s++) begin : g_side
            localparam int B = l * SIDES + s;
            role_e role;
            assign role     = (wr_side[l] == 1'(s)) ? ROLE_WRITE : ROLE_READ;
            assign b_ret[B] = ret_v_q && (ret_bank_q == BANK_IDX_W'(B));

            ppab_bank #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .AW(BANK_AW)) u_bank (
                .clk       (clk),
                .rst       (rst),
                .role      (role),
                .swap      (frame_swap),
                .push      (push_valid[l]),
                .push_data (push_data[l*DATA_W +: DATA_W]),
                .pop       (pop_req[l]),
                .gnt       (arb_gnt[B]),
                .ret_valid (b_ret[B]),
                .ret_data  (mem_rdata),
                .req       (b_req[B]),
                .req_we    (b_we[B]),
                .req_off   (b_off[B]),
                .req_wdata (b_wdata[B]),
                .head      (b_head[B]),
                .avail     (b_avail[B]),
                .can_push  (b_can_push[B])
            );
        end
    end

    always_comb begin
        for (int l = 0; l < NUM_LINKS; l++) begin
            pop_valid[l]                    = b_avail[bank_of(l, ~wr_side[l])];
            pop_data[l*DATA_W +: DATA_W]    = b_head[bank_of(l, ~wr_side[l])];
            link_can_push[l]                = b_can_push[bank_of(l, wr_side[l])];
        end
    end

    ppab_rr_arb #(.N(NUM_BANKS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (b_req),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    assign mem_en    = arb_any;
    assign mem_we    = arb_any && b_we[arb_idx];
    assign mem_addr  = {arb_idx, b_off[arb_idx]};
    assign mem_wdata = b_wdata[arb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_side    <= '0;
            ret_v_q    <= 1'b0;
            ret_bank_q <= '0;
            push_err   <= '0;
            pop_err    <= '0;
        end else begin
            if (frame_swap) wr_side <= ~wr_side;
            // A read granted in the swap cycle belongs to a queue that is
            // turning into a write queue: its data is not wanted.
            ret_v_q    <= arb_any && !b_we[arb_idx] && !frame_swap;
            ret_bank_q <= arb_idx;
            push_err   <= push_valid & ~link_can_push;
            pop_err    <= pop_req & ~pop_valid;
        end
    end

endmodule

// File: rtl/ppab_checker.sv
module ppab_checker import ppab_pkg::*; (
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_swap,
    input logic [NUM_LINKS-1:0] push_valid,
    input logic [NUM_LINKS-1:0] push_err,
    input logic [NUM_LINKS-1:0] pop_req,
    input logic [NUM_LINKS-1:0] pop_valid,
    input logic [NUM_LINKS-1:0] pop_err,
    input logic [NUM_BANKS-1:0] gnt
);

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R8

    AST_SWAP_HIDES_HEAD: assert property (@(posedge clk) disable iff (rst)
        frame_swap |=> (pop_valid == '0)); // R3

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_chk
        AST_PUSH_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
            push_err[l] |-> $past(push_valid[l])); // R5

        AST_POP_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
            pop_err[l] |-> $past(pop_req[l] && !pop_valid[l])); // R4

        AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
            $fell(pop_valid[l]) |-> $past(pop_req[l] || frame_swap)); // R1
    end

endmodule

bind pingpong_addr_buf ppab_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_swap (frame_swap),
    .push_valid (push_valid),
    .push_err   (push_err),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pop_err    (pop_err),
    .gnt        (arb_gnt)
);

// File: tb/sim_pingpong_addr_buf.sv
`timescale 1ns/1ps
module sim_pingpong_addr_buf;

    localparam int DW = 32;
    localparam int FD = 4;
    localparam int AW = 4;
    localparam int MW = AW + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_swap = 1'b0;
    logic [1:0]    push_valid = '0;
    logic [2*DW-1:0] push_data = '0;
    logic [1:0]    push_err;
    logic [1:0]    pop_req = '0;
    logic [1:0]    pop_valid;
    logic [2*DW-1:0] pop_data;
    logic [1:0]    pop_err;
    logic          mem_en, mem_we;
    logic [MW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] ram [64];

    always #2 clk = ~clk;

    pingpong_addr_buf #(.DATA_W(DW), .FIFO_DEPTH(FD), .BANK_AW(AW)) u0 (
        .clk(clk), .rst(rst), .frame_swap(frame_swap),
        .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data), .pop_err(pop_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] wq [2][32];
    logic [DW-1:0] rq [2][32];
    int wn [2], rn [2], rh [2], rej [2];
    int wcount [4], rcount [4];
    bit sel [2];
    bit pend_push [2], pend_pop [2], pend_bad [2];
    logic [DW-1:0] pend_dat [2];
    bit just_swapped = 0, idle_chk = 0;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gen(int f, int l, int i);
        return {8'hC3 ^ 8'(f), 8'(l + 1), 8'(f * 7 + i), 8'(i)};
    endfunction

    // One cycle, called at a negedge.
    task automatic step(bit sw, bit [1:0] pv, logic [DW-1:0] d0, logic [DW-1:0] d1,
                        bit [1:0] want_pop, bit [1:0] force_pop);
        if (mem_en) begin
            int b = int'(mem_addr[MW-1:AW]);
            int off = int'(mem_addr[AW-1:0]);
            if (mem_we) begin
                chk(off == wcount[b], "R7", "write offset", 64'(off), 64'(wcount[b]));
                wcount[b]++;
            end else begin
                chk(off == rcount[b], "R7", "read offset", 64'(off), 64'(rcount[b]));
                rcount[b]++;
            end
        end
        if (idle_chk) chk(mem_en == 1'b0, "R8", "idle port", 64'(mem_en), 64'(0));
        if (just_swapped) chk(pop_valid == 2'b00, "R3", "pop_valid after swap", 64'(pop_valid), 64'(0));
        for (int l = 0; l < 2; l++) begin
            if (pend_push[l]) begin
                if (push_err[l]) rej[l]++;
                else if (wn[l] < 32) begin
                    wq[l][wn[l]] = pend_dat[l];
                    wn[l]++;
                end
            end else begin
                chk(push_err[l] == 1'b0, "R5", "spurious push_err", 64'(push_err[l]), 64'(0));
            end
            chk(pop_err[l] == (pend_pop[l] && pend_bad[l]), "R4", "pop_err",
                64'(pop_err[l]), 64'(pend_pop[l] && pend_bad[l]));
        end
        frame_swap = sw;
        push_valid = pv;
        push_data  = {d1, d0};
        pend_push[0] = pv[0]; pend_dat[0] = d0;
        pend_push[1] = pv[1]; pend_dat[1] = d1;
        for (int l = 0; l < 2; l++) begin
            pop_req[l]  = 1'b0;
            pend_pop[l] = 0;
            pend_bad[l] = 0;
            if (force_pop[l] || (want_pop[l] && pop_valid[l])) begin
                pop_req[l]  = 1'b1;
                pend_pop[l] = 1;
                pend_bad[l] = !pop_valid[l];
                if (pop_valid[l]) begin
                    if (rh[l] < rn[l])
                        chk(pop_data[l*DW +: DW] == rq[l][rh[l]], "R1", "popped entry",
                            64'(pop_data[l*DW +: DW]), 64'(rq[l][rh[l]]));
                    else
                        chk(0, "R2", "entry beyond frame", 64'(pop_data[l*DW +: DW]), 64'(0));
                    rh[l]++;
                end
            end
        end
        if (sw) begin
            for (int l = 0; l < 2; l++) begin
                for (int i = 0; i < 32; i++) rq[l][i] = wq[l][i];
                rn[l] = wn[l];
                rh[l] = 0;
                wn[l] = 0;
                sel[l] = !sel[l];
                wcount[l*2 + int'(sel[l])]  = 0;
                rcount[l*2 + int'(!sel[l])] = 0;
            end
        end
        just_swapped = sw;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(int f, int n0, int n1, int period, bit [1:0] popen,
                             bit force_early, int len);
        rej[0] = 0; rej[1] = 0;
        step(1'b1, 2'b00, '0, '0, popen, 2'b00);
        for (int c = 1; c < len; c++) begin
            bit [1:0] pv;
            int k = (c - 2) / period;
            bit slot = (c >= 2) && ((c - 2) % period == 0);
            pv[0] = slot && (k < n0);
            pv[1] = slot && (k < n1);
            step(1'b0, pv, gen(f, 0, k), gen(f, 1, k), popen,
                 (force_early && c == 1) ? 2'b11 : 2'b00);
        end
        for (int l = 0; l < 2; l++)
            if (popen[l]) chk(rh[l] == rn[l], "R1", "entries delivered in frame",
                              64'(rh[l]), 64'(rn[l]));
    endtask

    initial begin
        for (int l = 0; l < 2; l++) begin
            wn[l] = 0; rn[l] = 0; rh[l] = 0; rej[l] = 0; sel[l] = 0;
            pend_push[l] = 0; pend_pop[l] = 0; pend_bad[l] = 0; pend_dat[l] = '0;
        end
        for (int b = 0; b < 4; b++) begin wcount[b] = 0; rcount[b] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pop_valid == 2'b00, "R3", "pop_valid after reset", 64'(pop_valid), 64'(0));
        chk(mem_en == 1'b0, "R8", "port idle after reset", 64'(mem_en), 64'(0));
        chk(push_err == 2'b00 && pop_err == 2'b00, "R4", "errors after reset",
            64'({push_err, pop_err}), 64'(0));

        // Sweep the per-link entry count over the full queue capacity.
        for (int f = 0; f <= 16; f++) begin
            run_frame(f, f, 16 - f, 4, 2'b11, 1'b1, 110);
            chk(rej[0] == 0 && rej[1] == 0, "R5", "no rejection at slow rate",
                64'(rej[0] + rej[1]), 64'(0));
        end
        run_frame(17, 0, 0, 4, 2'b11, 1'b1, 110);

        // Capacity limit: 17 pushes into a 16-entry queue.
        run_frame(18, 17, 5, 4, 2'b11, 1'b1, 110);
        chk(rej[0] == 1, "R6", "rejections beyond capacity", 64'(rej[0]), 64'(1));
        chk(wn[0] == 16, "R6", "entries kept at capacity", 64'(wn[0]), 64'(16));
        run_frame(19, 0, 0, 4, 2'b11, 1'b1, 110);

        // Front FIFO overflow: back-to-back pushes with two queues competing.
        run_frame(20, 12, 12, 1, 2'b11, 1'b1, 110);
        for (int l = 0; l < 2; l++) begin
            chk(rej[l] >= 1, "R5", "burst overflow rejected", 64'(rej[l]), 64'(1));
            chk(wn[l] + rej[l] == 12, "R5", "accepted plus rejected", 64'(wn[l] + rej[l]), 64'(12));
        end
        run_frame(21, 0, 0, 4, 2'b11, 1'b1, 110);

        // Unread entries are dropped at the next swap.
        run_frame(22, 6, 6, 4, 2'b11, 1'b1, 110);
        run_frame(23, 3, 3, 4, 2'b00, 1'b0, 110);
        chk(pop_valid == 2'b11, "R2", "unread entries waiting", 64'(pop_valid), 64'(3));
        run_frame(24, 0, 0, 4, 2'b11, 1'b1, 110);
        for (int l = 0; l < 2; l++)
            chk(rh[l] == 3 && rn[l] == 3, "R2", "only newest frame read", 64'(rh[l]), 64'(3));

        // Nothing to write or fetch: the memory port stays idle.
        run_frame(25, 0, 0, 4, 2'b11, 1'b1, 110);
        idle_chk = 1;
        run_frame(26, 0, 0, 4, 2'b11, 1'b1, 110);
        idle_chk = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule